// File: doc/BRIEF.md
# Real-Mode Interrupt Vector Fetcher

This block turns an interrupt or exception vector number into a new code segment and instruction pointer. The vector number is scaled into a byte offset within a table of four-byte far pointers. The block checks that the whole entry lies within the current table limit. It then reads the entry as two 16-bit words over a simple memory read port with a ready handshake: the offset word first, then the segment word.

The table base and limit are held in a small register. This register resets to physical address 0 with limit 3FFh, which covers 256 entries. It can be reloaded through a load strobe. The fetch takes a snapshot of the base when a request is accepted, so a reload during a fetch only affects later requests.

If an entry would cross the limit, the block raises a one-cycle fault pulse and issues no read. Vectors in this mode never carry an error code.

Top module: `ivec_fetch`

## Requirements
- R1: After reset the table base is 0 and the limit is 3FFh. The outputs `done`, `limit_fault` and `mem_rd` are 0, `req_ready` is 1, and `new_cs` and `new_ip` are 0. Vector 255 fetches without a fault under these defaults.
- R2: The first read of a fetch is at address base + vector*4. It starts in the cycle after the request is accepted.
- R3: The second read is at base + vector*4 + 2. When the fetch completes, `new_ip` holds the word from the first read and `new_cs` holds the word from the second.
- R4: Each read holds `mem_rd` and `mem_addr` steady until `mem_ready` is seen. With w wait cycles per read, `done` rises 2 + 2w cycles after the cycle that follows acceptance.
- R5: `done` is high for exactly one cycle. `new_cs` and `new_ip` change only in that cycle and hold their values through later requests until the next completion.
- R6: If vector*4 + 3 exceeds the limit, no read is issued and `done` does not rise. Instead `limit_fault` is high for exactly the one cycle after acceptance, and `new_cs` and `new_ip` keep their values.
- R7: A pulse on `tbl_load` loads `tbl_base_in` and `tbl_limit_in`. A load made while a fetch runs does not change that fetch's addresses, but it applies to the next request.
- R8: Read addresses wrap modulo 2^20.
- R9: `err_code_valid` is always 0.
- R10: A request is accepted only while `req_ready` is 1, that is, while no fetch is active. `req_valid` held during a fetch starts no extra reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Vector request |
| req_vector | input | 8 | Vector number |
| req_ready | output | 1 | Block idle, request can be taken |
| tbl_load | input | 1 | Load strobe for table base and limit |
| tbl_base_in | input | 20 | New table base |
| tbl_limit_in | input | 16 | New table limit |
| mem_rd | output | 1 | Read request |
| mem_addr | output | 20 | Read byte address |
| mem_rdata | input | 16 | Read data |
| mem_ready | input | 1 | Read data valid, read finishes |
| done | output | 1 | Fetch complete pulse |
| new_cs | output | 16 | Handler segment |
| new_ip | output | 16 | Handler offset |
| limit_fault | output | 1 | Entry beyond limit pulse |
| err_code_valid | output | 1 | Error code present, always 0 |

## Verification
A sequencer stuck in the wrong phase shows at once at the ports. The second read goes to the wrong word, `done` arrives a cycle early or late against the 2 + 2w count, or a read is issued for a faulting vector. A bad base snapshot or a bad scale factor shows up as a wrong `mem_addr` on the first read after acceptance. Stale or swapped capture registers show up as wrong `new_cs` or `new_ip` in the `done` cycle, or as values that drift between completions.

// File: rtl/ivf_pkg.sv
package ivf_pkg;
   localparam int unsigned WORD_W      = 16;
   localparam int unsigned ENTRY_BYTES = 4;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_RD_OFF  = 2'd1,
      ST_RD_SEG  = 2'd2,
      ST_DONE    = 2'd3
   } ivf_state_t;
endpackage

// File: rtl/ivf_tbl_reg.sv
module ivf_tbl_reg #(
   parameter int unsigned      ADDR_W    = 20,
   parameter int unsigned      LIM_W     = 16,
   parameter logic [ADDR_W-1:0] RST_BASE  = '0,
   parameter logic [LIM_W-1:0]  RST_LIMIT = 16'h03FF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] base_in,
   input  logic [LIM_W-1:0]  limit_in,
   output logic [ADDR_W-1:0] base_q,
   output logic [LIM_W-1:0]  limit_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q  <= RST_BASE;
         limit_q <= RST_LIMIT;
      end else if (load) begin
         base_q  <= base_in;
         limit_q <= limit_in;
      end
   end

   // R7: a load strobe is reflected in the register on the next cycle
   a_r7_load_takes: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (base_q == $past(base_in)) && (limit_q == $past(limit_in)));
endmodule

// File: rtl/ivf_addr_gen.sv
module ivf_addr_gen #(
   parameter int unsigned ADDR_W      = 20,
   parameter int unsigned LIM_W       = 16,
   parameter int unsigned VEC_W       = 8,
   parameter bit          CHECK_LIMIT = 1'b1
) (
   input  logic [VEC_W-1:0]  vec,
   input  logic [ADDR_W-1:0] base,
   input  logic [LIM_W-1:0]  limit,
   input  logic              seg_sel,
   output logic [ADDR_W-1:0] addr,
   output logic              over_limit
);
   localparam int unsigned OFF_W = VEC_W + 2;
   localparam int unsigned CMP_W = (OFF_W + 1 > LIM_W) ? OFF_W + 1 : LIM_W;

   logic [OFF_W-1:0] entry_off;
   assign entry_off = {vec, 2'b00};

   assign addr = base + ADDR_W'(entry_off) + (seg_sel ? ADDR_W'(2) : '0);

   generate
      if (CHECK_LIMIT) begin : g_limit_cmp
         logic [CMP_W-1:0] last_byte;
         assign last_byte  = CMP_W'(entry_off) + CMP_W'(ivf_pkg::ENTRY_BYTES - 1);
         assign over_limit = last_byte > CMP_W'(limit);
      end else begin : g_no_limit
         logic unused_lim;
         assign unused_lim = ^limit;
         assign over_limit = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/ivf_seq.sv
module ivf_seq
   import ivf_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic req_valid,
   input  logic over_limit,
   input  logic mem_ready,
   output logic req_ready,
   output logic accept,
   output logic mem_rd,
   output logic seg_phase,
   output logic cap_off,
   output logic cap_seg,
   output logic done,
   output logic limit_fault
);
   ivf_state_t state_q, state_d;
   logic       fault_q;

   assign req_ready = (state_q == ST_IDLE);
   assign accept    = req_valid && req_ready;
   assign seg_phase = (state_q == ST_RD_SEG);
   assign mem_rd    = (state_q == ST_RD_OFF) || seg_phase;
   assign cap_off   = (state_q == ST_RD_OFF) && mem_ready;
   assign cap_seg   = seg_phase && mem_ready;
   assign done      = (state_q == ST_DONE);
   assign limit_fault = fault_q;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:   if (accept && !over_limit) state_d = ST_RD_OFF;
         ST_RD_OFF: if (mem_ready)             state_d = ST_RD_SEG;
         ST_RD_SEG: if (mem_ready)             state_d = ST_DONE;
         ST_DONE:                              state_d = ST_IDLE;
         default:                              state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         fault_q <= 1'b0;
      end else begin
         state_q <= state_d;
         fault_q <= accept && over_limit;
      end
   end

   // R5: completion pulse lasts one cycle
   a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R3: the segment read always follows a finished offset read
   a_r3_seg_order: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(seg_phase) |-> $past(cap_off));
endmodule

// File: rtl/ivec_fetch.sv
module ivec_fetch
   import ivf_pkg::*;
#(
   parameter int unsigned       ADDR_W      = 20,
   parameter int unsigned       LIM_W       = 16,
   parameter int unsigned       VEC_W       = 8,
   parameter logic [ADDR_W-1:0] RST_BASE    = '0,
   parameter logic [LIM_W-1:0]  RST_LIMIT   = 16'h03FF,
   parameter bit                CHECK_LIMIT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [VEC_W-1:0]  req_vector,
   output logic              req_ready,
   input  logic              tbl_load,
   input  logic [ADDR_W-1:0] tbl_base_in,
   input  logic [LIM_W-1:0]  tbl_limit_in,
   output logic              mem_rd,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [WORD_W-1:0] mem_rdata,
   input  logic              mem_ready,
   output logic              done,
   output logic [WORD_W-1:0] new_cs,
   output logic [WORD_W-1:0] new_ip,
   output logic              limit_fault,
   output logic              err_code_valid
);
   generate
      if (ADDR_W <= VEC_W + 2) begin : g_chk_addr
         $error("ivec_fetch: ADDR_W must exceed VEC_W + 2");
      end
      if (LIM_W < 2) begin : g_chk_lim
         $error("ivec_fetch: LIM_W too small");
      end
   endgenerate

   logic [ADDR_W-1:0] base_live, base_snap, base_sel;
   logic [LIM_W-1:0]  limit_live;
   logic [VEC_W-1:0]  vec_q, vec_sel;
   logic [WORD_W-1:0] ip_tmp, cs_q, ip_q;
   logic              accept, seg_phase, cap_off, cap_seg, over_limit;

   ivf_tbl_reg #(
      .ADDR_W(ADDR_W), .LIM_W(LIM_W), .RST_BASE(RST_BASE), .RST_LIMIT(RST_LIMIT)
   ) i_tbl (
      .clk(clk), .rst_n(rst_n), .load(tbl_load),
      .base_in(tbl_base_in), .limit_in(tbl_limit_in),
      .base_q(base_live), .limit_q(limit_live)
   );

   assign vec_sel  = req_ready ? req_vector : vec_q;
   assign base_sel = req_ready ? base_live  : base_snap;

   ivf_addr_gen #(
      .ADDR_W(ADDR_W), .LIM_W(LIM_W), .VEC_W(VEC_W), .CHECK_LIMIT(CHECK_LIMIT)
   ) i_addr (
      .vec(vec_sel), .base(base_sel), .limit(limit_live),
      .seg_sel(seg_phase), .addr(mem_addr), .over_limit(over_limit)
   );

   ivf_seq i_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .over_limit(over_limit),
      .mem_ready(mem_ready), .req_ready(req_ready), .accept(accept),
      .mem_rd(mem_rd), .seg_phase(seg_phase), .cap_off(cap_off),
      .cap_seg(cap_seg), .done(done), .limit_fault(limit_fault)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vec_q     <= '0;
         base_snap <= '0;
         ip_tmp    <= '0;
         cs_q      <= '0;
         ip_q      <= '0;
      end else begin
         if (accept) begin
            vec_q     <= req_vector;
            base_snap <= base_live;
         end
         if (cap_off) ip_tmp <= mem_rdata;
         if (cap_seg) begin
            cs_q <= mem_rdata;
            ip_q <= ip_tmp;
         end
      end
   end

   assign new_cs         = cs_q;
   assign new_ip         = ip_q;
   assign err_code_valid = 1'b0;

   // R4: a pending read keeps its request and address
   a_r4_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd && !mem_ready |=> mem_rd && $stable(mem_addr));
   // R6: a fault pulse never coincides with a read or a completion
   a_r6_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      limit_fault |-> !mem_rd && !done);
   // R5: handler outputs move only in the completion cycle
   a_r5_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(new_cs) && $stable(new_ip));
   // R2: an accepted in-limit request starts a read on the next cycle
   a_r2_read_follows: assert property (@(posedge clk) disable iff (!rst_n)
      accept && !over_limit |=> mem_rd);
endmodule

// File: tb/test_ivec_fetch.sv
module test_ivec_fetch;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [7:0]  req_vector = '0;
   logic        req_ready;
   logic        tbl_load = 1'b0;
   logic [19:0] tbl_base_in = '0;
   logic [15:0] tbl_limit_in = '0;
   logic        mem_rd;
   logic [19:0] mem_addr;
   logic [15:0] mem_rdata = '0;
   logic        mem_ready = 1'b0;
   logic        done, limit_fault, err_code_valid;
   logic [15:0] new_cs, new_ip;

   int checks = 0;
   int errors = 0;

   int          waits = 0;
   int          wcnt = 0;
   int          nreads = 0;
   logic [19:0] rlog [0:7];

   bit got_done, got_fault;
   int cyc;

   ivec_fetch i_ivec_fetch (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vector(req_vector),
      .req_ready(req_ready), .tbl_load(tbl_load), .tbl_base_in(tbl_base_in),
      .tbl_limit_in(tbl_limit_in), .mem_rd(mem_rd), .mem_addr(mem_addr),
      .mem_rdata(mem_rdata), .mem_ready(mem_ready), .done(done),
      .new_cs(new_cs), .new_ip(new_ip), .limit_fault(limit_fault),
      .err_code_valid(err_code_valid)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [15:0] mdata(input logic [19:0] a);
      return a[15:0] ^ 16'h3C5A ^ {12'h0, a[19:16]};
   endfunction

   function automatic logic [19:0] eaddr(input logic [19:0] b, input int v, input int seg);
      logic [20:0] s;
      s = {1'b0, b} + 21'(v * 4) + 21'(seg * 2);
      return s[19:0];
   endfunction

   // memory model: answers after 'waits' idle cycles of each read
   always @(negedge clk) begin
      if (mem_rd) begin
         if (wcnt >= waits) begin
            mem_ready = 1'b1;
            mem_rdata = mdata(mem_addr);
            if (nreads < 8) rlog[nreads] = mem_addr;
            nreads++;
            wcnt = 0;
         end else begin
            mem_ready = 1'b0;
            wcnt++;
         end
      end else begin
         mem_ready = 1'b0;
         wcnt = 0;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic wait_end();
      cyc = 0;
      got_done = 1'b0;
      got_fault = 1'b0;
      while (!done && !limit_fault && cyc < 200) begin
         @(negedge clk);
         cyc++;
      end
      got_done = done;
      got_fault = limit_fault;
   endtask

   task automatic start_req(input logic [7:0] v);
      nreads = 0;
      @(negedge clk);
      req_valid = 1'b1;
      req_vector = v;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic do_load(input logic [19:0] b, input logic [15:0] l);
      @(negedge clk);
      tbl_load = 1'b1;
      tbl_base_in = b;
      tbl_limit_in = l;
      @(negedge clk);
      tbl_load = 1'b0;
   endtask

   task automatic t_good(input logic [7:0] v, input logic [19:0] b, input int w, input string req);
      logic [19:0] a0, a1;
      waits = w;
      start_req(v);
      wait_end();
      a0 = eaddr(b, v, 0);
      a1 = eaddr(b, v, 1);
      chk(got_done && !got_fault, req, "done without fault", {30'b0, got_fault, got_done}, 32'h1);
      chk(nreads == 2, req, "read count", nreads, 2);
      chk(rlog[0] == a0, "R2", "offset word address", rlog[0], a0);
      chk(rlog[1] == a1, "R3", "segment word address", rlog[1], a1);
      chk(new_ip == mdata(a0) && new_cs == mdata(a1), "R3", "cs:ip",
          {new_cs, new_ip}, {mdata(a1), mdata(a0)});
      chk(cyc == 2 + 2 * w, "R4", "cycles to done", cyc, 2 + 2 * w);
      chk(err_code_valid == 1'b0, "R9", "error code flag", err_code_valid, 0);
      @(negedge clk);
      chk(!done, "R5", "done width", done, 0);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(!done && !limit_fault && !mem_rd && req_ready, "R1", "reset controls",
          {28'b0, done, limit_fault, mem_rd, req_ready}, 32'h1);
      chk(new_cs == 0 && new_ip == 0, "R1", "reset cs:ip", {new_cs, new_ip}, 0);
      chk(err_code_valid == 1'b0, "R9", "error code at reset", err_code_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_hold();
      logic [15:0] cs0, ip0;
      cs0 = new_cs;
      ip0 = new_ip;
      repeat (5) @(negedge clk);
      chk(new_cs == cs0 && new_ip == ip0, "R5", "hold while idle", {new_cs, new_ip}, {cs0, ip0});
      waits = 2;
      start_req(8'h40);
      repeat (3) @(negedge clk);
      chk(new_cs == cs0 && new_ip == ip0, "R5", "hold during next fetch", {new_cs, new_ip}, {cs0, ip0});
      wait_end();
      @(negedge clk);
   endtask

   task automatic t_fault(input logic [7:0] v);
      logic [15:0] cs0, ip0;
      cs0 = new_cs;
      ip0 = new_ip;
      waits = 0;
      start_req(v);
      chk(limit_fault === 1'b1 && !done, "R6", "fault right after accept", {30'b0, limit_fault, done}, 32'h2);
      @(negedge clk);
      chk(!limit_fault, "R6", "fault width", limit_fault, 0);
      repeat (4) @(negedge clk);
      chk(nreads == 0 && !done, "R6", "no reads after fault", nreads, 0);
      chk(new_cs == cs0 && new_ip == ip0, "R6", "cs:ip kept on fault", {new_cs, new_ip}, {cs0, ip0});
   endtask

   task automatic t_load_mid();
      logic [19:0] a0;
      waits = 3;
      nreads = 0;
      @(negedge clk);
      req_valid = 1'b1;
      req_vector = 8'h03;
      @(negedge clk);
      req_valid = 1'b0;
      tbl_load = 1'b1;
      tbl_base_in = 20'h12340;
      tbl_limit_in = 16'h03FF;
      @(negedge clk);
      tbl_load = 1'b0;
      wait_end();
      a0 = eaddr(20'h00000, 3, 0);
      chk(got_done && rlog[0] == a0, "R7", "in-flight fetch keeps old base", rlog[0], a0);
      @(negedge clk);
      t_good(8'h03, 20'h12340, 0, "R7");
   endtask

   task automatic t_busy();
      logic [19:0] a0;
      waits = 3;
      start_req(8'h07);
      req_valid = 1'b1;
      req_vector = 8'h09;
      chk(!req_ready, "R10", "not ready while busy", req_ready, 0);
      repeat (3) @(negedge clk);
      req_valid = 1'b0;
      wait_end();
      a0 = eaddr(20'h0, 7, 0);
      chk(got_done && rlog[0] == a0, "R10", "first vector served", rlog[0], a0);
      repeat (5) @(negedge clk);
      chk(nreads == 2 && !done, "R10", "no extra fetch", nreads, 2);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      t_reset();
      t_good(8'h00, 20'h0, 0, "R1");
      t_good(8'hFF, 20'h0, 1, "R1");
      t_good(8'h21, 20'h0, 3, "R4");
      t_hold();
      do_load(20'h0, 16'h00FF);
      t_good(8'h3F, 20'h0, 0, "R6");
      t_fault(8'h40);
      do_load(20'h0, 16'h03FE);
      t_fault(8'hFF);
      do_load(20'hFFFF0, 16'h03FF);
      t_good(8'h05, 20'hFFFF0, 1, "R8");
      do_load(20'h0, 16'h03FF);
      t_load_mid();
      do_load(20'h0, 16'h03FF);
      t_busy();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule